// File: doc/BRIEF.md
# Write-Back Write-Allocate Cache Controller

This block places a small direct-mapped cache between a processor and a slower word memory. Each line holds one data word plus a tag, a valid flag and a dirty flag. Stores that hit change only the cached copy and mark the line dirty, so memory goes stale until that line is evicted. Any miss first sends the victim line back to memory, but only if it is dirty. It then fetches the requested word. A store miss merges its data into the fetched line and marks it dirty. A load miss leaves the line clean.

Both sides use valid/ready handshakes. A processor request is taken in a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` stays low from then until the response has been given, which is how the processor is stalled. The response is a one-cycle `cpu_resp_valid` pulse and cannot be held off. On the memory side the controller keeps a request and its fields steady while `mem_req_ready` is low. A write finishes at its handshake. Read data comes back later as a `mem_rvalid` pulse. Addresses are word addresses: the low `IDX_W` bits pick the line and the upper `TAG_W` bits form the tag.

Top module: `wbc_cache_top`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is high, and neither `mem_req_valid` nor `cpu_resp_valid` is asserted. The first access to any line therefore misses.
- R2: A load hit makes no memory request and returns the cached word. `cpu_resp_valid` is high in the second cycle after the cycle in which the request was accepted.
- R3: A store hit makes no memory request. It updates the cached word and sets the line dirty, and the memory word stays unchanged.
- R4: A miss on a line that is invalid or clean makes exactly one memory request: a read (`mem_req_write`=0) of the requested word address.
- R5: A miss on a valid dirty line makes exactly two memory requests. The first is a write of the victim word to address {victim tag, index}. The second is the read.
- R6: A load miss returns the word read from memory and leaves the line valid and clean, so a later eviction of that line writes nothing back.
- R7: A store miss fetches the line, replaces the word with the store data, and leaves the line valid and dirty. Its response carries the stored word.
- R8: `cpu_req_ready` is low from the cycle after acceptance through the response cycle. `cpu_resp_valid` lasts exactly one cycle per request. Every response (load or store) returns the line's current word on `cpu_resp_rdata`.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction and data stay stable. Read data is taken only from a `mem_rvalid` pulse that follows the read handshake.
- R10: Two addresses with the same index and different tags, accessed in alternation, miss on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request (low = stall) |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | TAG_W+IDX_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_resp_valid | output | 1 | One-cycle response strobe |
| cpu_resp_rdata | output | DATA_W | Line word after the access |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = fill read |
| mem_req_addr | output | TAG_W+IDX_W | Memory word address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_rvalid | input | 1 | Fill data strobe |
| mem_rdata | input | DATA_W | Fill data |

## Verification
The hit response is the only result with a fixed delay. It is due exactly two cycles after the accepting cycle, and the bench compares the response cycle number against the accept cycle number for every hit. A miss takes a time that depends on the stall pattern of the memory model and on its read latency. For misses the monitor therefore waits for the response strobe. At that point it checks the returned word, the number of memory handshakes, and the write-back address and data that the bench's own line model predicted. The monitor samples all outputs on the falling edge, half a cycle away from the edge where they change.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WB,
    ST_ALLOC,
    ST_RESP
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             mark_dirty
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] dty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
    end else if (fill_en) begin
      vld_q[idx] <= 1'b1;
      dty_q[idx] <= fill_dirty;
    end else if (mark_dirty) begin
      dty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign line_valid = vld_q[idx];
  assign line_dirty = dty_q[idx];
  assign line_tag   = tag_q[idx];

  // R6/R7: a fill leaves the line valid with the requested dirty state
  a_r6_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld_q[$past(idx)]);
  a_r7_fill_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (dty_q[$past(idx)] == $past(fill_dirty)));
  // R3: store hit marks the line dirty
  a_r3_mark_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    mark_dirty |=> dty_q[$past(idx)]);
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
  import wbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req_valid,
  input  logic       req_write,
  input  logic       hit,
  input  logic       victim_dirty,
  input  logic       mem_req_ready,
  input  logic       mem_rvalid,
  output wbc_state_e state,
  output logic       cpu_req_ready,
  output logic       latch_en,
  output logic       mark_dirty,
  output logic       fill_en,
  output logic       mem_req_valid,
  output logic       mem_req_write,
  output logic       resp_valid
);
  wbc_state_e st_q, st_d;
  logic       rd_issued_q;

  always_comb begin
    st_d          = st_q;
    cpu_req_ready = 1'b0;
    latch_en      = 1'b0;
    mark_dirty    = 1'b0;
    fill_en       = 1'b0;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    resp_valid    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cpu_req_ready = 1'b1;
        latch_en      = cpu_req_valid;
        if (cpu_req_valid) st_d = ST_CMP;
      end
      ST_CMP: begin
        if (hit) begin
          mark_dirty = req_write;
          st_d       = ST_RESP;
        end else if (victim_dirty) begin
          st_d = ST_WB;
        end else begin
          st_d = ST_ALLOC;
        end
      end
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        if (mem_req_ready) st_d = ST_ALLOC;
      end
      ST_ALLOC: begin
        mem_req_valid = !rd_issued_q;
        if (rd_issued_q && mem_rvalid) begin
          fill_en = 1'b1;
          st_d    = ST_RESP;
        end
      end
      ST_RESP: begin
        resp_valid = 1'b1;
        st_d       = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rd_issued_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ALLOC && mem_req_valid && mem_req_ready)
        rd_issued_q <= 1'b1;
      else if (fill_en)
        rd_issued_q <= 1'b0;
    end
  end

  assign state = st_q;

  // R2: a hit goes straight to the response with no memory request
  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMP && hit) |=> (!mem_req_valid && resp_valid));
  // R8: one response strobe per request
  a_r8_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

// File: rtl/wbc_cache_top.sv
module wbc_cache_top
  import wbc_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req_valid,
  output logic                   cpu_req_ready,
  input  logic                   cpu_req_write,
  input  logic [TAG_W+IDX_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0]      cpu_req_wdata,
  output logic                   cpu_resp_valid,
  output logic [DATA_W-1:0]      cpu_resp_rdata,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_req_write,
  output logic [TAG_W+IDX_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0]      mem_req_wdata,
  input  logic                   mem_rvalid,
  input  logic [DATA_W-1:0]      mem_rdata
);
  localparam int ADDR_W = TAG_W + IDX_W;

  logic [ADDR_W-1:0] req_addr_q;
  logic              req_write_q;
  logic [DATA_W-1:0] req_wdata_q;

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic              hit, victim_dirty;
  logic              latch_en, mark_dirty, fill_en;
  logic              data_we;
  logic [DATA_W-1:0] data_wr, data_rd;
  wbc_state_e        state;

  assign req_idx = req_addr_q[IDX_W-1:0];
  assign req_tag = req_addr_q[ADDR_W-1:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr_q  <= '0;
      req_write_q <= 1'b0;
      req_wdata_q <= '0;
    end else if (latch_en) begin
      req_addr_q  <= cpu_req_addr;
      req_write_q <= cpu_req_write;
      req_wdata_q <= cpu_req_wdata;
    end
  end

  wbc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (req_idx),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag),
    .fill_en    (fill_en),
    .fill_tag   (req_tag),
    .fill_dirty (req_write_q),
    .mark_dirty (mark_dirty)
  );

  assign hit          = line_valid && (line_tag == req_tag);
  assign victim_dirty = line_valid && line_dirty;

  assign data_we = mark_dirty || fill_en;
  assign data_wr = (fill_en && !req_write_q) ? mem_rdata : req_wdata_q;

  wbc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .we    (data_we),
    .idx   (req_idx),
    .wdata (data_wr),
    .rdata (data_rd)
  );

  wbc_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .req_write     (req_write_q),
    .hit           (hit),
    .victim_dirty  (victim_dirty),
    .mem_req_ready (mem_req_ready),
    .mem_rvalid    (mem_rvalid),
    .state         (state),
    .cpu_req_ready (cpu_req_ready),
    .latch_en      (latch_en),
    .mark_dirty    (mark_dirty),
    .fill_en       (fill_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .resp_valid    (cpu_resp_valid)
  );

  assign mem_req_addr   = mem_req_write ? {line_tag, req_idx} : req_addr_q;
  assign mem_req_wdata  = data_rd;
  assign cpu_resp_rdata = data_rd;

  // R5: a write-back is only issued for a valid dirty victim
  a_r5_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (line_valid && line_dirty));
  // R9: a stalled memory request holds its fields
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));
  // R8: no new request is taken while a response is pending
  a_r8_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB || state == ST_ALLOC) |-> !cpu_req_ready);
endmodule

// File: tb/wbc_cache_top_test.sv
module wbc_cache_top_test;
  localparam int TAG_W  = 6;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int LINES  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req_valid = 1'b0;
  logic              cpu_req_ready;
  logic              cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic              cpu_resp_valid;
  logic [DATA_W-1:0] cpu_resp_rdata;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic              mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_rvalid = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  wbc_cache_top #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_rdata(cpu_resp_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int acc_cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // memory model with periodic back-pressure and two-cycle read latency
  logic [DATA_W-1:0] bmem [WORDS];
  logic [2:0]        bp_cnt = '0;
  logic              pend = 1'b0;
  logic              pcnt = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;

  assign mem_req_ready = (bp_cnt[1:0] != 2'b10);

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    bp_cnt <= bp_cnt + 3'd1;
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (pcnt == 1'b0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= bmem[paddr];
        pend       <= 1'b0;
      end else begin
        pcnt <= 1'b0;
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) bmem[mem_req_addr] <= mem_req_wdata;
      else begin
        pend  <= 1'b1;
        pcnt  <= 1'b1;
        paddr <= mem_req_addr;
      end
    end
  end

  // bench model of the cache from the requirements
  logic [DATA_W-1:0] ref_val [WORDS];
  logic [DATA_W-1:0] shadow  [WORDS];
  logic              m_vld [LINES];
  logic              m_dty [LINES];
  logic [TAG_W-1:0]  m_tag [LINES];

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] rdata;
    int                nmem;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;
  } exp_t;

  exp_t q[$];
  int   txn = 0;

  task automatic access(input logic [ADDR_W-1:0] a, input bit w,
                        input logic [DATA_W-1:0] d);
    exp_t e;
    logic [IDX_W-1:0] ix;
    logic [TAG_W-1:0] tg;
    ix = a[IDX_W-1:0];
    tg = a[ADDR_W-1:IDX_W];
    e.addr = a;
    e.wb_addr = '0;
    e.wb_data = '0;
    if (m_vld[ix] && m_tag[ix] == tg) begin
      e.nmem = 0;
      if (w) begin ref_val[a] = d; m_dty[ix] = 1'b1; end
    end else begin
      if (m_vld[ix] && m_dty[ix]) begin
        e.nmem = 2;
        e.wb_addr = {m_tag[ix], ix};
        e.wb_data = ref_val[e.wb_addr];
        shadow[e.wb_addr] = e.wb_data;
      end else begin
        e.nmem = 1;
      end
      m_vld[ix] = 1'b1;
      m_tag[ix] = tg;
      m_dty[ix] = w;
      if (w) ref_val[a] = d;
    end
    e.rdata = ref_val[a];
    q.push_back(e);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = w;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    @(negedge clk);
    acc_cyc = cyc;
    cpu_req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        txn++;
        if (q.size() == 0) chk(1'b0, "R4", "memory request with no access", 32'(mem_req_addr), 0);
        else if (mem_req_write)
        begin
          chk(q[0].nmem == 2 && txn == 1, "R5", "write-back order", 32'(txn), 1);
          chk(mem_req_addr == q[0].wb_addr, "R5", "write-back address",
              32'(mem_req_addr), 32'(q[0].wb_addr));
          chk(mem_req_wdata == q[0].wb_data, "R5", "write-back data",
              mem_req_wdata, q[0].wb_data);
        end else begin
          chk(mem_req_addr == q[0].addr, "R4", "fill read address",
              32'(mem_req_addr), 32'(q[0].addr));
        end
      end
      if (cpu_resp_valid) begin
        if (q.size() == 0) chk(1'b0, "R8", "response with no access", 0, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cpu_resp_rdata == e.rdata, "R6", "response word", cpu_resp_rdata, e.rdata);
          chk(txn == e.nmem, "R5", "memory requests per access", 32'(txn), 32'(e.nmem));
          chk(!cpu_req_ready, "R8", "ready low in response cycle", 32'(cpu_req_ready), 0);
          if (e.nmem == 0)
            chk(cyc == acc_cyc + 1, "R2", "hit latency", 32'(cyc - acc_cyc), 1);
          chk(bmem[e.addr] == shadow[e.addr], "R3", "memory word (stale allowed)",
              bmem[e.addr], shadow[e.addr]);
        end
        txn = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < WORDS; i++) begin
      bmem[i]    = (32'(i) * 32'h9E37) ^ 32'h5A5A_0000;
      ref_val[i] = bmem[i];
      shadow[i]  = bmem[i];
    end
    for (int i = 0; i < LINES; i++) begin
      m_vld[i] = 1'b0; m_dty[i] = 1'b0; m_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: idle outputs during and after reset
    chk(cpu_req_ready == 1'b1, "R1", "ready in reset", 32'(cpu_req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req_valid == 1'b0, "R1", "no memory request", 32'(mem_req_valid), 0);
    chk(cpu_resp_valid == 1'b0, "R1", "no response", 32'(cpu_resp_valid), 0);
    chk(cpu_req_ready == 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 1);

    // R1/R4/R6: cold load misses on every line
    for (int i = 0; i < LINES; i++) access(ADDR_W'(i), 1'b0, '0);
    // R2: load hits
    for (int i = 0; i < LINES; i++) access(ADDR_W'(i), 1'b0, '0);
    // R3: store hits, then load them back
    for (int i = 0; i < 8; i++) access(ADDR_W'(i), 1'b1, 32'hC0DE_0000 + 32'(i));
    for (int i = 0; i < 8; i++) access(ADDR_W'(i), 1'b0, '0);
    // R5: dirty victims evicted by loads
    for (int i = 0; i < 8; i++) access(ADDR_W'(LINES + i), 1'b0, '0);
    // R6: clean victims evicted by loads
    for (int i = 8; i < LINES; i++) access(ADDR_W'(2*LINES + i), 1'b0, '0);
    // R7: store miss on clean line, then on the now dirty line
    access(ADDR_W'(3*LINES + 2), 1'b1, 32'hABCD_1234);
    access(ADDR_W'(3*LINES + 2), 1'b0, '0);
    access(ADDR_W'(4*LINES + 2), 1'b1, 32'h1357_9BDF);
    access(ADDR_W'(3*LINES + 2), 1'b0, '0);
    // R10: alternating conflicting addresses
    for (int i = 0; i < 8; i++) access(ADDR_W'((i % 2 == 0) ? 5 : 5 + 7*LINES), 1'b0, '0);
    // R9: mixed traffic under memory back-pressure
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access({4'b0, lfsr[5:4], lfsr[3:0]}, lfsr[8], {lfsr, lfsr ^ 16'h5A5A});
    end
    repeat (4) @(negedge clk);
    chk(mem_req_valid == 1'b0, "R8", "quiet when idle", 32'(mem_req_valid), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule